// File: doc/BRIEF.md
# Trace Stimulus Write Decoder

This block is the memory-mapped stimulus region of a system trace source. Software writes a payload into a channel's address window, and the address alone says what to emit. The upper address bits select the channel. The low eight bits select the packet kind and its attribute requests. The block checks each write against the size rules, the channel range and the channel enables. An accepted write leaves one trace record on a valid/ready output. The record carries the channel, kind, attributes, payload and payload size.

Attributes are requested by clearing bits of the kind's base offset, so every cleared attribute bit asserts that attribute. A write that asks for guaranteed delivery waits on the bus until the record slot is free. Other writes never stall the bus: when the slot is busy they are lost and a sticky overflow flag is raised. A 32-bit enable mask gates the channels. It applies either to every group of 32 channels, or, when group selection is on, to one chosen group only.

Top module: `trace_stim_decoder`

## Requirements
- R1: The channel is `wr_addr[ADDR_W-1:8]`, so each channel owns 256 bytes. The channel count is `CNT_CODE`, and a code of 0 means 32 channels. A write to a channel at or above the count produces no record.
- R2: The kind is decoded from offset `wr_addr[7:0]`. Base offsets are 0x98 for data (code 0 on `rec_kind`), 0xE8 for flag (code 1) and 0xF8 for trigger (code 2). Any offset that matches no kind once its allowed attribute bits are considered produces no record.
- R3: A cleared offset bit 3 asserts `rec_stamp`, and a cleared bit 7 asserts `rec_guaranteed`; both apply to every kind. A cleared bit 4 asserts `rec_marked`, and this applies only to data packets.
- R4: `wr_size` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. Code 3 produces no record unless `FUND_64` is set. Payload bytes above the size are zero in the record.
- R5: A flag record always has size code 0 and only the low payload byte, whatever size and data were written.
- R6: No record is produced while `glob_en` is low. No record is produced for a channel whose mask bit `port_mask[channel % 32]` is low.
- R7: With `port_sel_en` high, only channels in the 32-channel group numbered `port_grp_sel` are enabled, each by its mask bit `port_mask[channel % 32]`.
- R8: An accepted guaranteed write holds `wr_ready` low while a record is pending and `rec_ready` is low. Its record is delivered once the slot frees.
- R9: An accepted non-guaranteed write that arrives while a record is pending and `rec_ready` is low is dropped with `wr_ready` high, and it sets `overflow`. `overflow` stays set until reset.
- R10: While `rec_valid` is high and `rec_ready` is low, every record field holds its value.
- R11: After reset, `rec_valid` and `overflow` are low. A record appears on the cycle after its write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glob_en | input | 1 | Global trace enable |
| port_mask | input | 32 | Per-channel enable mask |
| port_sel_en | input | 1 | Restrict the mask to one channel group |
| port_grp_sel | input | GRP_W | Selected 32-channel group |
| wr_valid | input | 1 | Bus write valid |
| wr_ready | output | 1 | Bus write ready |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | PAY_W | Bus write data |
| wr_size | input | 2 | Bus write size code |
| rec_valid | output | 1 | Record valid |
| rec_ready | input | 1 | Record accepted by consumer |
| rec_channel | output | CH_W | Record channel |
| rec_kind | output | 2 | Record kind code |
| rec_stamp | output | 1 | Timestamp requested |
| rec_marked | output | 1 | Marked data |
| rec_guaranteed | output | 1 | Guaranteed delivery |
| rec_payload | output | PAY_W | Record payload |
| rec_size | output | 2 | Record size code |
| overflow | output | 1 | Sticky dropped-record flag |

## Verification
The bench aims at offsets one bit away from a valid kind, such as a trigger with bit 5 cleared, or bit 0 set. A decoder that compared too few offset bits would emit records for these. It also sends a cleared bit 7 on a flag and on a trigger, where a design that tied guaranteed delivery to data alone would lose the attribute. It writes to channel 37, which aliases mask bit 5 of channel 5, with group selection both off and on, and to the first channel past the count. Wrong group decoding enables or blocks the wrong channel there. The bench then holds the output blocked and offers one guaranteed write and one non-guaranteed write. A design that swapped the two policies would either drop the guaranteed write or hang the bus on the other one.

// File: rtl/trace_stim_pkg.sv
package trace_stim_pkg;

   typedef enum logic [1:0] {
      KIND_DATA = 2'd0,
      KIND_FLAG = 2'd1,
      KIND_TRIG = 2'd2
   } stim_kind_e;

   // base offsets inside a channel window, all attribute bits set
   localparam logic [7:0] BASE_DATA = 8'h98;
   localparam logic [7:0] BASE_FLAG = 8'hE8;
   localparam logic [7:0] BASE_TRIG = 8'hF8;

   // attribute bit positions inside the offset (cleared = requested)
   localparam int STAMP_BIT = 3;
   localparam int MARK_BIT  = 4;
   localparam int GUAR_BIT  = 7;

   localparam logic [7:0] ATTR_ALL   = 8'((1 << STAMP_BIT) | (1 << MARK_BIT) | (1 << GUAR_BIT));
   localparam logic [7:0] ATTR_NOMRK = 8'((1 << STAMP_BIT) | (1 << GUAR_BIT));

   localparam int WIN_BITS = 8;

endpackage

// File: rtl/tsd_offset_decode.sv
module tsd_offset_decode
   import trace_stim_pkg::*;
(
   input  logic [7:0]  offset,
   output logic        hit,
   output stim_kind_e  kind,
   output logic        stamp,
   output logic        marked,
   output logic        guar
);

   logic hit_data, hit_flag, hit_trig;

   // every attribute bit of a base offset must be set, or clearing it is meaningless
   if ((BASE_DATA & ATTR_ALL) != ATTR_ALL) begin : g_bad_data
      $error("data base offset lacks an attribute bit");
   end
   if (((BASE_FLAG & ATTR_NOMRK) != ATTR_NOMRK) || ((BASE_TRIG & ATTR_NOMRK) != ATTR_NOMRK)) begin : g_bad_ft
      $error("flag/trigger base offset lacks an attribute bit");
   end

   always_comb begin
      hit_data = (offset | ATTR_ALL)   == BASE_DATA;
      hit_flag = (offset | ATTR_NOMRK) == BASE_FLAG;
      hit_trig = (offset | ATTR_NOMRK) == BASE_TRIG;
      hit      = hit_data | hit_flag | hit_trig;
      if (hit_flag)      kind = KIND_FLAG;
      else if (hit_trig) kind = KIND_TRIG;
      else               kind = KIND_DATA;
      stamp  = ~offset[STAMP_BIT];
      guar   = ~offset[GUAR_BIT];
      marked = hit_data & ~offset[MARK_BIT];
   end

endmodule

// File: rtl/tsd_payload_shape.sv
module tsd_payload_shape #(
   parameter int PAY_W   = 64,
   parameter bit FUND_64 = 1'b0
) (
   input  logic [PAY_W-1:0] in_data,
   input  logic [1:0]       in_size,
   input  logic             is_flag,
   output logic             size_ok,
   output logic [1:0]       out_size,
   output logic [PAY_W-1:0] out_data
);

   localparam int NBYTES = PAY_W / 8;

   if (PAY_W != 32 && PAY_W != 64) begin : g_bad_w
      $error("PAY_W must be 32 or 64");
   end
   if (FUND_64 && PAY_W < 64) begin : g_bad_f
      $error("64-bit writes need a 64-bit payload");
   end

   if (FUND_64) begin : g_size64
      assign size_ok = 1'b1;
   end else begin : g_size32
      assign size_ok = (in_size != 2'd3);
   end

   assign out_size = is_flag ? 2'd0 : in_size;

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign out_data[8*b +: 8] = (4'(b) < (4'd1 << out_size)) ? in_data[8*b +: 8] : 8'h00;
   end

endmodule

// File: rtl/tsd_port_gate.sv
module tsd_port_gate #(
   parameter int NUM_CH = 64,
   parameter int CH_W   = 6,
   parameter int GRP_W  = 1
) (
   input  logic [CH_W-1:0]  chan,
   input  logic             glob_en,
   input  logic [31:0]      port_mask,
   input  logic             port_sel_en,
   input  logic [GRP_W-1:0] port_grp_sel,
   output logic             chan_en
);

   localparam int NUM_GRP = (NUM_CH + 31) / 32;

   logic [4:0] bit_idx;
   logic       grp_hit;

   if (CH_W >= 5) begin : g_wide
      assign bit_idx = chan[4:0];
   end else begin : g_narrow
      assign bit_idx = {{(5 - CH_W){1'b0}}, chan};
   end

   if (NUM_GRP > 1) begin : g_multi
      assign grp_hit = (chan[CH_W-1:5] == port_grp_sel);
   end else begin : g_single
      assign grp_hit = (port_grp_sel == '0);
   end

   assign chan_en = glob_en & port_mask[bit_idx] & (~port_sel_en | grp_hit);

endmodule

// File: rtl/tsd_record_stage.sv
module tsd_record_stage
   import trace_stim_pkg::*;
#(
   parameter int CH_W  = 6,
   parameter int PAY_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             ovf_set,
   input  logic [CH_W-1:0]  in_channel,
   input  stim_kind_e       in_kind,
   input  logic             in_stamp,
   input  logic             in_marked,
   input  logic             in_guar,
   input  logic [PAY_W-1:0] in_payload,
   input  logic [1:0]       in_size,
   output logic             slot_free,
   output logic             rec_valid,
   input  logic             rec_ready,
   output logic [CH_W-1:0]  rec_channel,
   output logic [1:0]       rec_kind,
   output logic             rec_stamp,
   output logic             rec_marked,
   output logic             rec_guaranteed,
   output logic [PAY_W-1:0] rec_payload,
   output logic [1:0]       rec_size,
   output logic             overflow
);

   assign slot_free = ~rec_valid | rec_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_valid      <= 1'b0;
         rec_channel    <= '0;
         rec_kind       <= '0;
         rec_stamp      <= 1'b0;
         rec_marked     <= 1'b0;
         rec_guaranteed <= 1'b0;
         rec_payload    <= '0;
         rec_size       <= '0;
         overflow       <= 1'b0;
      end else begin
         if (load) begin
            rec_valid      <= 1'b1;
            rec_channel    <= in_channel;
            rec_kind       <= in_kind;
            rec_stamp      <= in_stamp;
            rec_marked     <= in_marked;
            rec_guaranteed <= in_guar;
            rec_payload    <= in_payload;
            rec_size       <= in_size;
         end else if (rec_ready) begin
            rec_valid <= 1'b0;
         end
         if (ovf_set) overflow <= 1'b1;
      end
   end

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && !rec_ready |=> rec_valid && $stable(rec_channel) && $stable(rec_kind)
         && $stable(rec_stamp) && $stable(rec_marked) && $stable(rec_guaranteed)
         && $stable(rec_payload) && $stable(rec_size));

   assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   assert_flag_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && rec_kind == KIND_FLAG |-> rec_size == 2'd0 && (rec_payload >> 8) == '0);

   assert_mark_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && rec_kind != KIND_DATA |-> !rec_marked);

endmodule

// File: rtl/trace_stim_decoder.sv
module trace_stim_decoder
   import trace_stim_pkg::*;
#(
   parameter int          ADDR_W   = 16,
   parameter logic [16:0] CNT_CODE = 17'd64,
   parameter int          PAY_W    = 64,
   parameter bit          FUND_64  = 1'b0,
   localparam int NUM_CH  = (CNT_CODE == 17'd0) ? 32 : int'(CNT_CODE),
   localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int NUM_GRP = (NUM_CH + 31) / 32,
   localparam int GRP_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             glob_en,
   input  logic [31:0]      port_mask,
   input  logic             port_sel_en,
   input  logic [GRP_W-1:0] port_grp_sel,
   input  logic             wr_valid,
   output logic             wr_ready,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [PAY_W-1:0] wr_data,
   input  logic [1:0]       wr_size,
   output logic             rec_valid,
   input  logic             rec_ready,
   output logic [CH_W-1:0]  rec_channel,
   output logic [1:0]       rec_kind,
   output logic             rec_stamp,
   output logic             rec_marked,
   output logic             rec_guaranteed,
   output logic [PAY_W-1:0] rec_payload,
   output logic [1:0]       rec_size,
   output logic             overflow
);

   localparam int CHF_W = ADDR_W - WIN_BITS;

   if (ADDR_W <= WIN_BITS) begin : g_bad_addr
      $error("ADDR_W must exceed the channel window width");
   end
   if (NUM_CH > (1 << CHF_W)) begin : g_bad_cnt
      $error("channel count exceeds the address space");
   end

   localparam logic [CHF_W:0] CH_LIMIT = (CHF_W + 1)'(NUM_CH);

   logic [CHF_W-1:0] ch_field;
   logic [CH_W-1:0]  chan;
   logic             in_range;
   logic             off_hit, a_stamp, a_marked, a_guar;
   stim_kind_e       kind;
   logic             size_ok, chan_en;
   logic [1:0]       shp_size;
   logic [PAY_W-1:0] shp_data;
   logic             pkt_ok, slot_free, load, ovf_set;

   assign ch_field = wr_addr[ADDR_W-1:WIN_BITS];
   assign chan     = ch_field[CH_W-1:0];
   assign in_range = ({1'b0, ch_field} < CH_LIMIT);

   tsd_offset_decode i_offset (
      .offset (wr_addr[WIN_BITS-1:0]),
      .hit    (off_hit),
      .kind   (kind),
      .stamp  (a_stamp),
      .marked (a_marked),
      .guar   (a_guar)
   );

   tsd_payload_shape #(.PAY_W(PAY_W), .FUND_64(FUND_64)) i_shape (
      .in_data  (wr_data),
      .in_size  (wr_size),
      .is_flag  (kind == KIND_FLAG),
      .size_ok  (size_ok),
      .out_size (shp_size),
      .out_data (shp_data)
   );

   tsd_port_gate #(.NUM_CH(NUM_CH), .CH_W(CH_W), .GRP_W(GRP_W)) i_gate (
      .chan         (chan),
      .glob_en      (glob_en),
      .port_mask    (port_mask),
      .port_sel_en  (port_sel_en),
      .port_grp_sel (port_grp_sel),
      .chan_en      (chan_en)
   );

   assign pkt_ok   = off_hit & size_ok & in_range & chan_en;
   assign wr_ready = ~(pkt_ok & a_guar & ~slot_free);
   assign load     = wr_valid & pkt_ok & slot_free;
   assign ovf_set  = wr_valid & pkt_ok & ~a_guar & ~slot_free;

   tsd_record_stage #(.CH_W(CH_W), .PAY_W(PAY_W)) i_stage (
      .clk            (clk),
      .rst_n          (rst_n),
      .load           (load),
      .ovf_set        (ovf_set),
      .in_channel     (chan),
      .in_kind        (kind),
      .in_stamp       (a_stamp),
      .in_marked      (a_marked),
      .in_guar        (a_guar),
      .in_payload     (shp_data),
      .in_size        (shp_size),
      .slot_free      (slot_free),
      .rec_valid      (rec_valid),
      .rec_ready      (rec_ready),
      .rec_channel    (rec_channel),
      .rec_kind       (rec_kind),
      .rec_stamp      (rec_stamp),
      .rec_marked     (rec_marked),
      .rec_guaranteed (rec_guaranteed),
      .rec_payload    (rec_payload),
      .rec_size       (rec_size),
      .overflow       (overflow)
   );

   assert_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> int'(rec_channel) < NUM_CH);

   assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |-> rec_valid && !rec_ready);

   assert_stall_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> rec_valid);

   assert_ovf_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> $past(rec_valid && !rec_ready));

   assert_global_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rec_valid) |-> $past(glob_en));

   if (!FUND_64) begin : g_chk32
      assert_no_wide_R4: assert property (@(posedge clk) disable iff (!rst_n)
         rec_valid |-> rec_size != 2'd3);
   end

endmodule

// File: tb/test_trace_stim_decoder.sv
module test_trace_stim_decoder;

   localparam int CH_W  = 6;
   localparam int NVEC  = 22;
   localparam int LIMIT = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        glob_en = 1'b1;
   logic [31:0] port_mask = 32'hFFFF_FFFF;
   logic        port_sel_en = 1'b0;
   logic [0:0]  port_grp_sel = 1'b0;
   logic        wr_valid = 1'b0;
   logic        wr_ready;
   logic [15:0] wr_addr = '0;
   logic [63:0] wr_data = '0;
   logic [1:0]  wr_size = '0;
   logic        rec_valid;
   logic        rec_ready = 1'b1;
   logic [CH_W-1:0] rec_channel;
   logic [1:0]  rec_kind;
   logic        rec_stamp, rec_marked, rec_guaranteed;
   logic [63:0] rec_payload;
   logic [1:0]  rec_size;
   logic        overflow;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   trace_stim_decoder i_trace_stim_decoder (
      .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .port_mask(port_mask),
      .port_sel_en(port_sel_en), .port_grp_sel(port_grp_sel),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_size(wr_size), .rec_valid(rec_valid),
      .rec_ready(rec_ready), .rec_channel(rec_channel), .rec_kind(rec_kind),
      .rec_stamp(rec_stamp), .rec_marked(rec_marked),
      .rec_guaranteed(rec_guaranteed), .rec_payload(rec_payload),
      .rec_size(rec_size), .overflow(overflow)
   );

   // {addr, size, expect_record, kind, stamp, marked, guaranteed}
   localparam logic [24:0] VEC [NVEC] = '{
      {16'h0598, 2'd2, 1'b1, 2'd0, 3'b000},
      {16'h0590, 2'd2, 1'b1, 2'd0, 3'b100},
      {16'h0588, 2'd2, 1'b1, 2'd0, 3'b010},
      {16'h0518, 2'd2, 1'b1, 2'd0, 3'b001},
      {16'h0500, 2'd2, 1'b1, 2'd0, 3'b111},
      {16'h05E8, 2'd2, 1'b1, 2'd1, 3'b000},
      {16'h05E0, 2'd2, 1'b1, 2'd1, 3'b100},
      {16'h0568, 2'd2, 1'b1, 2'd1, 3'b001},
      {16'h05F8, 2'd2, 1'b1, 2'd2, 3'b000},
      {16'h05F0, 2'd2, 1'b1, 2'd2, 3'b100},
      {16'h0578, 2'd2, 1'b1, 2'd2, 3'b001},
      {16'h05D8, 2'd2, 1'b0, 2'd0, 3'b000},
      {16'h0599, 2'd2, 1'b0, 2'd0, 3'b000},
      {16'h3F08, 2'd2, 1'b1, 2'd0, 3'b011},
      {16'h4098, 2'd2, 1'b0, 2'd0, 3'b000},
      {16'h0098, 2'd0, 1'b1, 2'd0, 3'b000},
      {16'h0198, 2'd3, 1'b0, 2'd0, 3'b000},
      {16'h02E8, 2'd3, 1'b0, 2'd0, 3'b000},
      {16'h1F98, 2'd1, 1'b1, 2'd0, 3'b000},
      {16'h2098, 2'd2, 1'b1, 2'd0, 3'b000},
      {16'h0470, 2'd1, 1'b1, 2'd2, 3'b101},
      {16'h04E8, 2'd1, 1'b1, 2'd1, 3'b000}
   };

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] keep_bytes(input logic [63:0] d, input logic [1:0] s);
      logic [63:0] r = '0;
      for (int b = 0; b < 8; b++)
         if (b < (1 << s)) r[8*b +: 8] = d[8*b +: 8];
      return r;
   endfunction

   task automatic report;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic put(input logic [15:0] a, input logic [1:0] s);
      wr_valid = 1'b1; wr_addr = a; wr_size = s; wr_data = 64'hA1B2_C3D4_E5F6_0718;
   endtask

   initial begin
      repeat (LIMIT) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=%0d expected=<%0d cycles", LIMIT, LIMIT);
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      check(!rec_valid && !overflow, "R11 reset", {rec_valid, overflow}, 0);

      // main table: R1 R2 R3 R4 R5
      for (int i = 0; i < NVEC; i++) begin
         logic [15:0] a;
         logic [1:0]  s, k, es;
         logic        e;
         logic [2:0]  at;
         logic [63:0] d, ed;
         {a, s, e, k, at} = VEC[i];
         d  = 64'h8877_6655_4433_2211 + 64'h0101_0101_0101_0101 * i;
         es = (k == 2'd1) ? 2'd0 : s;
         ed = keep_bytes(d, es);
         wr_valid = 1'b1; wr_addr = a; wr_size = s; wr_data = d;
         @(negedge clk);
         check(rec_valid == e, "R1/R2/R4 record presence", 64'(rec_valid), 64'(e));
         if (e && rec_valid) begin
            check({rec_channel, rec_kind, rec_stamp, rec_marked, rec_guaranteed, rec_size}
                     == {a[13:8], k, at, es},
                  "R2/R3/R5 record fields",
                  64'({rec_channel, rec_kind, rec_stamp, rec_marked, rec_guaranteed, rec_size}),
                  64'({a[13:8], k, at, es}));
            check(rec_payload == ed, "R4/R5 payload", rec_payload, ed);
         end
      end
      wr_valid = 1'b0;
      @(negedge clk);

      // R6: global enable low
      glob_en = 1'b0; put(16'h0598, 2'd2);
      @(negedge clk);
      check(!rec_valid, "R6 global off", 64'(rec_valid), 0);
      glob_en = 1'b1;

      // R6: mask bit 5 clear blocks channel 5 and its alias channel 37
      port_mask = ~32'h20; put(16'h0598, 2'd2);
      @(negedge clk);
      check(!rec_valid, "R6 mask ch5", 64'(rec_valid), 0);
      put(16'h2598, 2'd2);
      @(negedge clk);
      check(!rec_valid, "R6 mask ch37", 64'(rec_valid), 0);
      put(16'h0698, 2'd2);
      @(negedge clk);
      check(rec_valid && rec_channel == 6'd6, "R6 mask ch6", 64'({rec_valid, rec_channel}), 64'({1'b1, 6'd6}));

      // R7: group select to group 1, mask bit 5 only
      port_mask = 32'h20; port_sel_en = 1'b1; port_grp_sel = 1'b1;
      put(16'h2598, 2'd2);
      @(negedge clk);
      check(rec_valid && rec_channel == 6'd37, "R7 group ch37", 64'({rec_valid, rec_channel}), 64'({1'b1, 6'd37}));
      put(16'h0598, 2'd2);
      @(negedge clk);
      check(!rec_valid, "R7 other group ch5", 64'(rec_valid), 0);
      port_mask = 32'hFFFF_FFFF; port_sel_en = 1'b0; port_grp_sel = 1'b0;
      wr_valid = 1'b0;
      @(negedge clk);

      // R8 / R10: guaranteed write stalls behind a blocked record
      rec_ready = 1'b0; put(16'h0198, 2'd2);
      @(negedge clk);
      check(rec_valid && rec_channel == 6'd1, "R11 one-cycle latency", 64'({rec_valid, rec_channel}), 64'({1'b1, 6'd1}));
      put(16'h0218, 2'd2);
      for (int c = 0; c < 3; c++) begin
         #1;
         check(!wr_ready, "R8 stall", 64'(wr_ready), 0);
         @(negedge clk);
         check(rec_valid && rec_channel == 6'd1 && !rec_guaranteed, "R10 hold",
               64'({rec_valid, rec_channel}), 64'({1'b1, 6'd1}));
      end
      rec_ready = 1'b1;
      #1;
      check(wr_ready, "R8 release", 64'(wr_ready), 1);
      @(negedge clk);
      check(rec_valid && rec_channel == 6'd2 && rec_guaranteed, "R8 delivered",
            64'({rec_valid, rec_channel, rec_guaranteed}), 64'({1'b1, 6'd2, 1'b1}));
      wr_valid = 1'b0; rec_ready = 1'b0;
      check(!overflow, "R9 no overflow yet", 64'(overflow), 0);

      // R9: non-guaranteed write dropped while blocked
      put(16'h0398, 2'd2);
      #1;
      check(wr_ready, "R9 no stall", 64'(wr_ready), 1);
      @(negedge clk);
      wr_valid = 1'b0;
      check(overflow, "R9 overflow set", 64'(overflow), 1);
      check(rec_valid && rec_channel == 6'd2, "R9 record kept", 64'({rec_valid, rec_channel}), 64'({1'b1, 6'd2}));
      rec_ready = 1'b1;
      @(negedge clk);
      check(!rec_valid, "R9 drained", 64'(rec_valid), 0);
      check(overflow, "R9 sticky", 64'(overflow), 1);

      report();
   end

endmodule